// File: doc/BRIEF.md
# Blocking Inter-Core FIFO Hub

This block gives a small cluster of I/O coprocessor cores a set of four shared 32-bit queues, each eight entries deep. Each core presents one access per cycle: a request, a direction (push or pop) and the index of the queue it targets. A push that cannot be stored and a pop that has nothing to return never fail and never drop data. Instead the block raises that core's stall output in the same cycle, and the core holds its instruction until the access goes through. When several cores reach for the same queue at once, a fixed order by core index decides, and every core that loses stalls for that cycle.

A host-side configuration port sets a fill threshold for each queue. Each queue drives one level flag, high while its occupancy is at or above that threshold. The four flags are meant to be wired into the hard-wired top byte of a shared event register that sits outside this block. The host can also flush any queue. A flush empties the queue and frees every core that is waiting on it, which is the way out of a deadlock in which all cores are blocked on one queue.

Top module: `core_fifo_hub`

## Requirements
- R1: After reset every queue is empty, every threshold is 8 and every level flag is 0.
- R2: Each queue returns its entries in the order they were pushed. The queue is chosen by the 2-bit field of `accSel` that belongs to the core, bits [2c+1:2c] for core c. Accesses by different cores to different queues all complete in the same cycle.
- R3: A push to a queue that holds 8 entries raises the core's `accStall` in that cycle and stores nothing. The push completes in the first cycle that starts with the queue not full.
- R4: A pop from an empty queue raises `accStall`. The pop completes in the first cycle that starts with the queue holding data, and in that same cycle `accRData` carries the oldest entry. An entry pushed in cycle t can be popped from cycle t+1.
- R5: At most one access per queue completes in a cycle. Among the requesting cores whose access could complete, the one with the lowest index wins, and the others stall. A core whose access cannot complete never blocks a lower-priority core whose access can.
- R6: A host write with `cfgWe` sets the threshold of queue `cfgSel` from the next cycle onward. Values above 8 are stored as 8. `levelFlag[f]` is 1 when the occupancy at the start of the cycle is greater than or equal to the threshold, so a threshold of 0 keeps the flag at 1.
- R7: In a cycle where `fifoFlush[f]` is 1, every access to queue f is released (no stall) and discarded, and a released pop returns 0. From the next cycle the queue is empty.
- R8: `accRData` for a core is 0 in every cycle in which that core does not complete a pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accReq | input | 4 | Per-core access request |
| accWrite | input | 4 | Per-core direction, 1 = push, 0 = pop |
| accSel | input | 8 | Per-core target queue index, 2 bits per core |
| accWData | input | 128 | Per-core push data, 32 bits per core |
| accRData | output | 128 | Per-core pop data, 32 bits per core, 0 unless a pop completes |
| accStall | output | 4 | Per-core halt request for an access that cannot complete this cycle |
| cfgWe | input | 1 | Host threshold write strobe |
| cfgSel | input | 2 | Queue whose threshold is written |
| cfgThresh | input | 4 | Threshold value, saturated to 8 |
| fifoFlush | input | 4 | Per-queue flush strobe |
| levelFlag | output | 4 | Per-queue occupancy-at-or-above-threshold flag |

## Verification
The embedded properties take for granted that inputs settle well before each rising edge. They assume no protocol at all from the cores: a stalled core may hold its request, change it or withdraw it. For this reason the stall, occupancy and pointer checks are stated per cycle and never assume that a stalled access is retried. The bench drives every input on the falling edge and runs directed sequences that fill, overrun, drain, contend and flush. A long random phase then lets cores drop and retarget requests freely and lets host writes include out-of-range threshold values.

// File: rtl/cfh_pkg.sv
`timescale 1ns/1ps
package cfh_pkg;
  parameter int NUM_CORES = 4;
  parameter int NUM_FIFOS = 4;
  parameter int DEPTH     = 8;
  parameter int WIDTH     = 32;

  localparam int SEL_W  = $clog2(NUM_FIFOS);
  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic [NUM_FIFOS-1:0]             push;
    logic [NUM_FIFOS-1:0]             pop;
    logic [NUM_FIFOS-1:0]             flush;
    logic [NUM_FIFOS-1:0][CORE_W-1:0] pushCore;
    logic [NUM_CORES-1:0]             readDone;
  } fifoStrobes_t;
endpackage

// File: rtl/cfh_arbiter.sv
`timescale 1ns/1ps
module cfh_arbiter #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gntId
);
  // lowest index has priority: scan downward, last hit wins
  always_comb begin
    gnt   = '0;
    gntId = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        gntId  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cfh_ctrl.sv
`timescale 1ns/1ps
module cfh_ctrl import cfh_pkg::*; (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_CORES-1:0]                accReq,
  input  logic [NUM_CORES-1:0]                accWrite,
  input  logic [NUM_CORES-1:0][SEL_W-1:0]     accSel,
  input  logic                                cfgWe,
  input  logic [SEL_W-1:0]                    cfgSel,
  input  logic [CNT_W-1:0]                    cfgThresh,
  input  logic [NUM_FIFOS-1:0]                fifoFlush,
  output fifoStrobes_t                        strb,
  output logic [NUM_CORES-1:0]                accStall,
  output logic [NUM_FIFOS-1:0]                levelFlag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [NUM_FIFOS-1:0][CNT_W-1:0]     count;
  logic [NUM_FIFOS-1:0][CNT_W-1:0]     thresh;
  logic [NUM_FIFOS-1:0]                isFull, isEmpty;
  logic [NUM_FIFOS-1:0][NUM_CORES-1:0] canGo;
  logic [NUM_FIFOS-1:0][NUM_CORES-1:0] grant;
  logic [NUM_FIFOS-1:0][CORE_W-1:0]    winId;
  logic [NUM_CORES-1:0]                granted, released;

  always_comb begin
    for (int f = 0; f < NUM_FIFOS; f++) begin
      isFull[f]  = (count[f] == FULL_CNT);
      isEmpty[f] = (count[f] == '0);
      for (int c = 0; c < NUM_CORES; c++) begin
        canGo[f][c] = accReq[c] && (accSel[c] == SEL_W'(f)) &&
                      (accWrite[c] ? !isFull[f] : !isEmpty[f]);
      end
    end
  end

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : gArb
    cfh_arbiter #(.N(NUM_CORES)) uArb (
      .req  (canGo[f]),
      .gnt  (grant[f]),
      .gntId(winId[f])
    );
  end

  // strobes to the datapath and stall generation
  always_comb begin
    strb = '0;
    for (int f = 0; f < NUM_FIFOS; f++) begin
      strb.flush[f]    = fifoFlush[f];
      strb.push[f]     = |(grant[f] & accWrite) && !fifoFlush[f];
      strb.pop[f]      = |(grant[f] & ~accWrite) && !fifoFlush[f];
      strb.pushCore[f] = winId[f];
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      granted[c]  = 1'b0;
      for (int f = 0; f < NUM_FIFOS; f++) granted[c] = granted[c] | grant[f][c];
      released[c] = fifoFlush[accSel[c]];
      accStall[c] = accReq[c] && !granted[c] && !released[c];
      strb.readDone[c] = accReq[c] && !accWrite[c] && granted[c] && !released[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      thresh <= {NUM_FIFOS{FULL_CNT}};
    end else begin
      for (int f = 0; f < NUM_FIFOS; f++) begin
        if (fifoFlush[f])      count[f] <= '0;
        else if (strb.push[f]) count[f] <= count[f] + 1'b1;
        else if (strb.pop[f])  count[f] <= count[f] - 1'b1;
      end
      if (cfgWe) thresh[cfgSel] <= (cfgThresh > FULL_CNT) ? FULL_CNT : cfgThresh;
    end
  end

  always_comb begin
    for (int f = 0; f < NUM_FIFOS; f++) levelFlag[f] = (count[f] >= thresh[f]);
  end

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : gFifoChk
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
      count[f] <= FULL_CNT) else $error("occupancy above depth");
    assert_one_winner_R5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grant[f])) else $error("two winners on one queue");
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
      fifoFlush[f] |=> count[f] == '0) else $error("flush left entries");
    assert_thresh_range_R6: assert property (@(posedge clk) disable iff (!rstN)
      thresh[f] <= FULL_CNT) else $error("threshold out of range");
    for (genvar c = 0; c < NUM_CORES; c++) begin : gCoreChk
      assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rstN)
        accReq[c] && accWrite[c] && accSel[c] == SEL_W'(f) && isFull[f] && !fifoFlush[f]
        |-> accStall[c]) else $error("push to full queue not stalled");
      assert_empty_stalls_R4: assert property (@(posedge clk) disable iff (!rstN)
        accReq[c] && !accWrite[c] && accSel[c] == SEL_W'(f) && isEmpty[f] && !fifoFlush[f]
        |-> accStall[c]) else $error("pop from empty queue not stalled");
    end
  end
endmodule

// File: rtl/cfh_dpath.sv
`timescale 1ns/1ps
module cfh_dpath import cfh_pkg::*; (
  input  logic                            clk,
  input  logic                            rstN,
  input  fifoStrobes_t                    strb,
  input  logic [NUM_CORES-1:0][SEL_W-1:0] accSel,
  input  logic [NUM_CORES-1:0][WIDTH-1:0] accWData,
  output logic [NUM_CORES-1:0][WIDTH-1:0] accRData
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0]                 mem [NUM_FIFOS][DEPTH];
  logic [NUM_FIFOS-1:0][PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextSlot(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    for (int f = 0; f < NUM_FIFOS; f++) begin
      if (strb.push[f]) mem[f][wrPtr[f]] <= accWData[strb.pushCore[f]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      for (int f = 0; f < NUM_FIFOS; f++) begin
        if (strb.flush[f]) begin
          wrPtr[f] <= '0;
          rdPtr[f] <= '0;
        end else begin
          if (strb.push[f]) wrPtr[f] <= nextSlot(wrPtr[f]);
          if (strb.pop[f])  rdPtr[f] <= nextSlot(rdPtr[f]);
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      accRData[c] = strb.readDone[c] ? mem[accSel[c]][rdPtr[accSel[c]]] : '0;
    end
  end

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : gPtrChk
    assert_single_op_R5: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.push[f] && strb.pop[f])) else $error("push and pop in one cycle");
    assert_head_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
      !strb.pop[f] && !strb.flush[f] |=> $stable(rdPtr[f])) else $error("head moved without pop");
  end
  for (genvar c = 0; c < NUM_CORES; c++) begin : gRdChk
    assert_read_has_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
      strb.readDone[c] |-> strb.pop[accSel[c]]) else $error("read data without pop");
  end
endmodule

// File: rtl/core_fifo_hub.sv
`timescale 1ns/1ps
module core_fifo_hub import cfh_pkg::*; (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES-1:0]          accReq,
  input  logic [NUM_CORES-1:0]          accWrite,
  input  logic [NUM_CORES*SEL_W-1:0]    accSel,
  input  logic [NUM_CORES*WIDTH-1:0]    accWData,
  output logic [NUM_CORES*WIDTH-1:0]    accRData,
  output logic [NUM_CORES-1:0]          accStall,
  input  logic                          cfgWe,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [CNT_W-1:0]              cfgThresh,
  input  logic [NUM_FIFOS-1:0]          fifoFlush,
  output logic [NUM_FIFOS-1:0]          levelFlag
);
  logic [NUM_CORES-1:0][SEL_W-1:0] selV;
  logic [NUM_CORES-1:0][WIDTH-1:0] wDataV, rDataV;
  fifoStrobes_t                    strb;

  assign selV     = accSel;
  assign wDataV   = accWData;
  assign accRData = rDataV;

  cfh_ctrl uCtrl (
    .clk, .rstN, .accReq, .accWrite, .accSel(selV),
    .cfgWe, .cfgSel, .cfgThresh, .fifoFlush,
    .strb, .accStall, .levelFlag
  );

  cfh_dpath uDpath (
    .clk, .rstN, .strb, .accSel(selV), .accWData(wDataV), .accRData(rDataV)
  );
endmodule

// File: tb/core_fifo_hub_test.sv
`timescale 1ns/1ps
module core_fifo_hub_test;
  import cfh_pkg::*;
  localparam int NC = NUM_CORES;
  localparam int NF = NUM_FIFOS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0]             accReq, accWrite, accStall;
  logic [NC-1:0][SEL_W-1:0]  accSel;
  logic [NC-1:0][WIDTH-1:0]  accWData, accRData;
  logic                      cfgWe;
  logic [SEL_W-1:0]          cfgSel;
  logic [CNT_W-1:0]          cfgThresh;
  logic [NF-1:0]             fifoFlush, levelFlag;

  core_fifo_hub uut (
    .clk, .rstN, .accReq, .accWrite, .accSel, .accWData, .accRData, .accStall,
    .cfgWe, .cfgSel, .cfgThresh, .fifoFlush, .levelFlag
  );

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] q[NF][$];
  int th[NF];

  task automatic check(input string tag, input string what, input logic [WIDTH-1:0] got,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    accReq = '0; accWrite = '0; accSel = '0; accWData = '0;
    cfgWe = 1'b0; cfgSel = '0; cfgThresh = '0; fifoFlush = '0;
  endtask

  task automatic drive(input int c, input bit w, input int f, input logic [WIDTH-1:0] d);
    accReq[c] = 1'b1; accWrite[c] = w; accSel[c] = SEL_W'(f); accWData[c] = d;
  endtask

  // one cycle: compare against model mid-cycle, then advance model at the edge
  task automatic step(input string tag);
    int win[NF];
    #1;
    for (int f = 0; f < NF; f++) begin
      check(tag, $sformatf("levelFlag[%0d]", f), WIDTH'(levelFlag[f]),
            WIDTH'(q[f].size() >= th[f]));
      win[f] = -1;
    end
    for (int c = 0; c < NC; c++) begin
      int f = int'(accSel[c]);
      if (accReq[c] && !fifoFlush[f] && win[f] < 0 &&
          (accWrite[c] ? q[f].size() < DEPTH : q[f].size() > 0)) win[f] = c;
    end
    for (int c = 0; c < NC; c++) begin
      int f = int'(accSel[c]);
      logic [WIDTH-1:0] expData;
      bit expStall;
      expStall = accReq[c] && !fifoFlush[f] && win[f] != c;
      expData  = (accReq[c] && !accWrite[c] && !fifoFlush[f] && win[f] == c) ? q[f][0] : '0;
      check(tag, $sformatf("accStall[%0d]", c), WIDTH'(accStall[c]), WIDTH'(expStall));
      check(tag, $sformatf("accRData[%0d]", c), accRData[c], expData);
    end
    @(posedge clk);
    for (int f = 0; f < NF; f++) begin
      if (fifoFlush[f]) q[f].delete();
      else if (win[f] >= 0) begin
        if (accWrite[win[f]]) q[f].push_back(accWData[win[f]]);
        else void'(q[f].pop_front());
      end
    end
    if (cfgWe) th[cfgSel] = (int'(cfgThresh) > DEPTH) ? DEPTH : int'(cfgThresh);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    for (int f = 0; f < NF; f++) th[f] = DEPTH;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, and a pop on an empty queue stalls (R4)
    step("R1");
    drive(0, 0, 0, '0); step("R4");

    // R2: parallel pushes to distinct queues, then ordered drain
    for (int i = 0; i < 3; i++) begin
      drive(0, 1, 1, 32'h1100 + i); drive(1, 1, 2, 32'h2200 + i);
      drive(2, 1, 3, 32'h3300 + i); step("R2");
    end
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 1, '0); drive(2, 0, 2, '0); drive(3, 0, 3, '0); step("R2");
    end

    // R3: fill queue 0, overrun stalls, pop frees one slot, held push completes
    for (int i = 0; i < DEPTH; i++) begin drive(0, 1, 0, 32'hA000 + i); step("R3"); end
    drive(0, 1, 0, 32'hA0FF); step("R3");
    drive(0, 1, 0, 32'hA0FF); step("R3");
    drive(0, 1, 0, 32'hA0FF); drive(1, 0, 0, '0); step("R3");
    drive(0, 1, 0, 32'hA0FF); step("R3");
    drive(0, 1, 0, 32'hA0FF); step("R3");
    for (int i = 0; i < DEPTH; i++) begin drive(3, 0, 0, '0); step("R2"); end

    // R4: blocked pop receives data the cycle after the push
    drive(2, 0, 3, '0); step("R4");
    drive(2, 0, 3, '0); drive(3, 1, 3, 32'hBEEF); step("R4");
    drive(2, 0, 3, '0); step("R4");
    drive(2, 0, 3, '0); step("R4");

    // R5: four cores push one queue, lowest index wins each cycle
    for (int r = 0; r < 4; r++) begin
      for (int c = r; c < NC; c++) drive(c, 1, 2, 32'h5000 + c);
      step("R5");
    end
    // R5: stalled pop at index 0 must not block a push at index 1 on an empty queue
    drive(0, 0, 1, '0); drive(1, 1, 1, 32'h7777); step("R5");
    drive(0, 0, 1, '0); drive(1, 1, 1, 32'h8888); step("R5");
    // R8: pushes and stalls return zero data
    drive(0, 1, 3, 32'h1); drive(1, 0, 0, '0); step("R8");

    // R6: thresholds 0, 3 and an out-of-range value saturating to 8
    cfgWe = 1; cfgSel = 2; cfgThresh = 0; step("R6");
    step("R6");
    cfgWe = 1; cfgSel = 2; cfgThresh = 3; step("R6");
    step("R6");
    cfgWe = 1; cfgSel = 1; cfgThresh = 4'd12; step("R6");
    for (int i = 0; i < DEPTH; i++) begin drive(0, 1, 1, 32'hC0 + i); step("R6"); end
    step("R6");

    // R7: flush a full queue while a pusher and popper wait
    drive(1, 1, 1, 32'hDEAD); step("R7");
    drive(1, 1, 1, 32'hDEAD); drive(2, 0, 1, '0); fifoFlush[1] = 1'b1;
    drive(3, 1, 2, 32'h9); step("R7");
    drive(2, 0, 1, '0); step("R7");
    step("R7");

    // random traffic across all rules
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 9) < 7)
          drive(c, bit'($urandom_range(0, 1)), $urandom_range(0, NF - 1), $urandom);
      end
      for (int f = 0; f < NF; f++) fifoFlush[f] = ($urandom_range(0, 99) < 2);
      if ($urandom_range(0, 19) == 0) begin
        cfgWe = 1; cfgSel = SEL_W'($urandom_range(0, NF - 1));
        cfgThresh = CNT_W'($urandom_range(0, 15));
      end
      step("R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule